// File: doc/BRIEF.md
# Write-only I2C register slave

This block is a receive-only I2C target that controls two small registers from a serial bus. It samples SCL and SDA with its own system clock, finds START and STOP conditions, and compares the first byte of each transfer with a fixed 7-bit device address. When the address matches and the transfer is a write, every later byte up to STOP is acknowledged and stored in one of the two registers.

Each data byte holds both the register select and the value. The top bit picks the register: 0 selects the mode register and 1 selects the volume register. The seven low bits are the new contents. The block has no read path. A read request is never acknowledged, and the rest of that transfer is ignored. The active-low reset clears both registers and makes the block ignore the bus while reset is held. The SDA output is a pull-down enable. The pad outside the block turns it into an open-drain driver.

Top module: `i2c_wr_regs`

## Requirements
- R1: The first byte after START is the address, sent MSB first. The value 0xDE (address 7'h6F followed by R/W=0) is acknowledged. Any other address byte gets no acknowledge, and the block ignores the bus until the next START.
- R2: The address 7'h6F with R/W=1 (byte 0xDF) gets no acknowledge, and the data bytes that follow in the same transfer leave both registers unchanged.
- R3: After an accepted address byte, and after every data byte, sdaPullDown rises while SCL is low, stays high through the ninth SCL high phase, and drops after the SCL falling edge that ends that ninth clock.
- R4: A data byte with bit 7 = 0 loads bits [6:0] into modeReg and leaves volReg unchanged.
- R5: A data byte with bit 7 = 1 loads bits [6:0] into volReg and leaves modeReg unchanged.
- R6: Any number of data bytes may follow one address. Each byte is stored and acknowledged in the order received, so a later byte to the same register overrides an earlier one.
- R7: After STOP, clocked bytes without a new START get no acknowledge and change no register.
- R8: While rstN is low, modeReg and volReg are 0, sdaPullDown is 0, and a complete write on the bus has no effect.
- R9: A repeated START in the middle of a transfer restarts address reception. Any partial byte received before it is discarded.
- R10: A STOP that arrives before the eighth bit of a data byte discards that byte, and no register changes.
- R11: After reset, both registers read 0 and SDA is released.
- R12: SCL and SDA are each synchronized through SYNC_STAGES flip-flops before edges are detected, and data bits are taken on SCL rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low reset: clears the registers and blanks the bus |
| sclIn | input | 1 | Bus clock as seen at the pad |
| sdaIn | input | 1 | Bus data as seen at the pad |
| sdaPullDown | output | 1 | 1 pulls SDA low (acknowledge) |
| modeReg | output | 7 | Mode register contents |
| volReg | output | 7 | Volume register contents |

## Verification
The bench targets the cases where the control sequencing can go wrong. A design that trusts only the address bits would acknowledge the 0xDF read request. A design that does not reset its bit counter on START or STOP would join a cut-off byte to the next one and write a shifted value. A design that stays armed after STOP would acknowledge bytes clocked without a START. A design that holds SDA low for too long would still be pulling it down after the acknowledge clock falls. The bench also runs a full write while reset is held, which exposes any path that still reacts to the bus during reset.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK
  } ctlState_t;

  // control -> datapath
  typedef struct packed {
    logic shift;
    logic clrBits;
    logic ackOn;
    logic ackOff;
    logic commit;
  } ctrlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startEv;
    logic stopEv;
    logic byteFull;
    logic addrMatch;
  } busEvents_t;
endpackage

// File: rtl/i2cw_datapath.sv
module i2cw_datapath
  import i2cw_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [6:0]  DEV_ADDR    = 7'h6F
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  ctrlStrobes_t     stb,
  output busEvents_t       ev,
  output logic             sdaPullDown,
  output logic [REG_W-1:0] modeReg,
  output logic [REG_W-1:0] volReg
);
  // synchronizers, reset to the idle (high) bus level
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclQ, sdaQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclS;
      sdaQ    <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  // shift register and bit counter
  logic [BYTE_W-1:0] shReg;
  logic [CNT_W-1:0]  bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
    end else if (stb.clrBits) begin
      bitCnt <= '0;
    end else if (stb.shift) begin
      shReg  <= {shReg[BYTE_W-2:0], sdaS};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // acknowledge driver
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sdaPullDown <= 1'b0;
    else if (stb.ackOff)  sdaPullDown <= 1'b0;
    else if (stb.ackOn)   sdaPullDown <= 1'b1;
  end

  // register file: top bit selects the target
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      volReg  <= '0;
    end else if (stb.commit) begin
      if (shReg[BYTE_W-1]) volReg  <= shReg[REG_W-1:0];
      else                 modeReg <= shReg[REG_W-1:0];
    end
  end

  assign ev.sclRise   = sclS & ~sclQ;
  assign ev.sclFall   = ~sclS & sclQ;
  assign ev.startEv   = sclS & sclQ & sdaQ & ~sdaS;
  assign ev.stopEv    = sclS & sclQ & ~sdaQ & sdaS;
  assign ev.byteFull  = (bitCnt == CNT_W'(BYTE_W));
  assign ev.addrMatch = (shReg[BYTE_W-1:1] == DEV_ADDR) && !shReg[0];
endmodule

// File: rtl/i2cw_control.sv
module i2cw_control
  import i2cw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  busEvents_t   ev,
  output ctrlStrobes_t stb
);
  ctlState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    stb = '0;
    nxt = state;
    if (ev.startEv) begin
      nxt         = ST_ADDR;
      stb.clrBits = 1'b1;
      stb.ackOff  = 1'b1;
    end else if (ev.stopEv) begin
      nxt         = ST_IDLE;
      stb.clrBits = 1'b1;
      stb.ackOff  = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR, ST_DATA: begin
          if (ev.sclRise && !ev.byteFull) begin
            stb.shift = 1'b1;
          end else if (ev.sclFall && ev.byteFull) begin
            if (state == ST_DATA) begin
              stb.commit = 1'b1;
              stb.ackOn  = 1'b1;
              nxt        = ST_ACK;
            end else if (ev.addrMatch) begin
              stb.ackOn  = 1'b1;
              nxt        = ST_ACK;
            end else begin
              stb.clrBits = 1'b1;
              nxt         = ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (ev.sclFall) begin
            stb.ackOff  = 1'b1;
            stb.clrBits = 1'b1;
            nxt         = ST_DATA;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_wr_regs.sv
module i2c_wr_regs
  import i2cw_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h6F
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaPullDown,
  output logic [REG_W-1:0] modeReg,
  output logic [REG_W-1:0] volReg
);
  busEvents_t   ev;
  ctrlStrobes_t stb;

  i2cw_datapath #(.SYNC_STAGES(SYNC_STAGES), .DEV_ADDR(DEV_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .ev(ev), .sdaPullDown(sdaPullDown), .modeReg(modeReg), .volReg(volReg)
  );

  i2cw_control u_ctl (
    .clk(clk), .rstN(rstN), .ev(ev), .stb(stb)
  );
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
  parameter int W = 7
) (
  input logic         clk,
  input logic         rstN,
  input logic         sclIn,
  input logic         sdaPullDown,
  input logic [W-1:0] modeReg,
  input logic [W-1:0] volReg
);
  // R8: reset holds everything cleared
  a_r8_reset_clears: assert property (@(posedge clk)
    !rstN |-> (modeReg == '0 && volReg == '0 && !sdaPullDown));

  // R3: acknowledge starts while SCL is low
  a_r3_ack_rise_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullDown) |-> !sclIn);

  // R3: acknowledge ends while SCL is low
  a_r3_ack_fall_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullDown) |-> !sclIn);

  // R4 / R5: one byte touches only one register
  a_r4_one_reg_per_byte: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeReg) |-> $stable(volReg));

  // R12: register updates follow an SCL falling edge, never SCL high
  a_r12_update_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(modeReg) || !$stable(volReg)) |-> !sclIn);

  // R3: acknowledge pulse lasts more than one cycle
  a_r3_ack_held: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullDown) |=> sdaPullDown);
endmodule

bind i2c_wr_regs i2cw_checker #(.W(i2cw_pkg::REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullDown(sdaPullDown),
  .modeReg(modeReg), .volReg(volReg)
);

// File: tb/tb_i2c_wr_regs.sv
`timescale 1ns/1ps
module tb_i2c_wr_regs;
  localparam int Q = 80;  // quarter bit period in ns (10 clocks)

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLine;
  logic sdaPullDown;
  logic [6:0] modeReg, volReg;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit expAckQ[$];
  bit obsAck;
  event ackSeen;

  always #4 clk = ~clk;  // 125 MHz

  assign sdaLine = sdaM & ~sdaPullDown;

  i2c_wr_regs dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .sdaPullDown(sdaPullDown), .modeReg(modeReg), .volReg(volReg)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares observed acknowledges against the scoreboard queue
  initial begin
    forever begin
      @(ackSeen);
      if (expAckQ.size() == 0) chk(1'b0, "R3 unexpected ack slot", obsAck, 0);
      else begin
        bit e;
        e = expAckQ.pop_front();
        chk(obsAck == e, "R1/R2/R3/R6/R7/R8 ack", obsAck, e);
      end
    end
  end

  task automatic startCond();
    sdaM = 1'b1; #Q; scl = 1'b1; #Q; sdaM = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic stopCond();
    sdaM = 1'b0; #Q; scl = 1'b1; #Q; sdaM = 1'b1; #Q;
  endtask

  task automatic sendBit(input bit b);
    sdaM = b; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
  endtask

  task automatic sendBits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) sendBit(v[i]);
  endtask

  task automatic sendByte(input logic [7:0] v, input bit expAck);
    expAckQ.push_back(expAck);
    sendBits(v, 8);
    sdaM = 1'b1; #Q; scl = 1'b1; #Q;
    obsAck = !sdaLine;
    -> ackSeen;
    #Q; scl = 1'b0; #(Q/2);
    chk(sdaPullDown == 1'b0, "R3 release after ack clock", sdaPullDown, 0);
    #(Q/2);
  endtask

  task automatic expRegs(input logic [6:0] m, input logic [6:0] v, input string tag);
    #(2*Q);
    chk(modeReg == m, {tag, " modeReg"}, modeReg, m);
    chk(volReg == v, {tag, " volReg"}, volReg, v);
  endtask

  initial begin
    #3;
    #(4*Q);
    // R11: reset state
    chk(modeReg == 0 && volReg == 0, "R11 regs in reset", {modeReg, volReg}, 0);
    chk(sdaPullDown == 0, "R11 sda released", sdaPullDown, 0);
    rstN = 1'b1;
    #(2*Q);
    expRegs(7'h00, 7'h00, "R11 after reset");

    // R4: mode write
    startCond(); sendByte(8'hDE, 1); sendByte(8'h03, 1); stopCond();
    expRegs(7'h03, 7'h00, "R4 mode write");

    // R5: volume write
    startCond(); sendByte(8'hDE, 1); sendByte(8'hBF, 1); stopCond();
    expRegs(7'h03, 7'h3F, "R5 volume write");

    // R6: multi-byte, later byte overrides
    startCond(); sendByte(8'hDE, 1); sendByte(8'h81, 1); sendByte(8'h02, 1);
    sendByte(8'h85, 1); stopCond();
    expRegs(7'h02, 7'h05, "R6 multi-byte");

    // R1: wrong address
    startCond(); sendByte(8'hDC, 0); sendByte(8'h90, 0); stopCond();
    expRegs(7'h02, 7'h05, "R1 wrong address");

    // R2: read request
    startCond(); sendByte(8'hDF, 0); sendByte(8'h00, 0); sendByte(8'h9A, 0); stopCond();
    expRegs(7'h02, 7'h05, "R2 read ignored");

    // R7: bytes after STOP without START
    scl = 1'b0; #Q;
    sendByte(8'hDE, 0); sendByte(8'h80, 0); stopCond();
    expRegs(7'h02, 7'h05, "R7 no start");

    // R9: repeated START discards partial byte
    startCond(); sendByte(8'hDE, 1); sendBits(8'h8A, 4);
    startCond(); sendByte(8'hDE, 1); sendByte(8'h87, 1); stopCond();
    expRegs(7'h02, 7'h07, "R9 repeated start");

    // R10: STOP mid-byte
    startCond(); sendByte(8'hDE, 1); sendBits(8'h11, 5); stopCond();
    expRegs(7'h02, 7'h07, "R10 stop mid-byte");

    // R4: all payload bits set
    startCond(); sendByte(8'hDE, 1); sendByte(8'h7F, 1); stopCond();
    expRegs(7'h7F, 7'h07, "R4 full payload");

    // R8: reset clears and blanks the bus
    rstN = 1'b0;
    #Q;
    chk(modeReg == 0 && volReg == 0, "R8 clear on reset", {modeReg, volReg}, 0);
    startCond(); sendByte(8'hDE, 0); sendByte(8'h85, 0); stopCond();
    expRegs(7'h00, 7'h00, "R8 bus ignored in reset");
    rstN = 1'b1;
    #(2*Q);
    startCond(); sendByte(8'hDE, 1); sendByte(8'h01, 1); stopCond();
    expRegs(7'h01, 7'h00, "R8 write after reset");

    #(2*Q);
    chk(expAckQ.size() == 0, "R3 ack slots consumed", expAckQ.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule